// File: doc/BRIEF.md
# Serial Bus Slave for a Clock Register Space

This block is the two-wire serial slave that connects a host to the 64-byte register space of a real-time clock. The space holds eight timekeeping and control bytes at the bottom, with 56 bytes of general-purpose RAM above them. The bus lines reach the block already synchronised to a fast system clock. The block drives the data line only by pulling it low, through an open-drain enable.

A six-bit address pointer lives inside the block and keeps its value from one transaction to the next. A read that carries no address phase therefore continues from where the last access left off. The block reaches the register storage through a plain port: an address, a write strobe with its data, and combinational read data. The seven live time bytes also arrive on a separate bus. The block copies them into a private snapshot when it accepts a read header, so a burst read returns one coherent time value. A power-fail input forces the block idle, clears the pointer and keeps it off the bus for as long as the input stays high.

Top module: `rtc_i2c_regif`

## Requirements
- R1: The header bytes D0h (write) and D1h (read) are acknowledged. These carry the 7-bit device address 1101000 followed by the read/write bit, with 1 meaning read. Any other header gets no acknowledge, and the block then ignores the bus (no ACK, no SDA drive, no register write) until the next START.
- R2: SDA falling while SCL is high is a START or repeated START, and it restarts header reception from any state. SDA rising while SCL is high is a STOP, and it returns the block to idle with SDA released.
- R3: A write is a header, one word-address byte whose low six bits load the pointer, then any number of data bytes. Each data byte is written at the pointer, the pointer then increments, and every byte is acknowledged.
- R4: The pointer is six bits wide and wraps from 3Fh to 00h, for writes and for reads alike.
- R5: A standard read (write header, address byte, repeated START, read header) returns bytes starting at that address. The pointer increments after each byte sent.
- R6: A simplified read (START, then a read header) returns bytes from the pointer left by the previous access. The pointer is 00h after reset.
- R7: The slave holds SDA low from the falling SCL edge after the 8th bit until the 9th falling edge. Every SDA change the slave makes happens while SCL is low.
- R8: When the master leaves a byte unacknowledged, the slave sends no further data and keeps SDA released until a START or STOP.
- R9: While the power-fail input is high, the block releases SDA, holds the pointer at 00h, writes nothing and acknowledges nothing. A transfer cut off this way is lost.
- R10: Reads of addresses 00h to 06h return the time bytes as they stood when the read header was accepted. Later changes to the time bus during that read do not appear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Synchronised serial clock line |
| sda_i | input | 1 | Synchronised serial data line, as seen on the wire |
| sda_oe | output | 1 | 1 pulls the data line low |
| pwr_fail | input | 1 | Supply out of tolerance; aborts and resets the interface |
| time_i | input | 56 | Live time bytes; byte n (address n) in bits 8n+7:8n |
| rf_addr | output | 6 | Register address, equal to the pointer |
| rf_we | output | 1 | One-cycle write strobe |
| rf_wdata | output | 8 | Write data |
| rf_rdata | input | 8 | Combinational read data at rf_addr |

## Verification
An error in the pointer shows up as bytes returned from the wrong address. That can surface several transactions later, because only a simplified read exposes the persisted value, so the bench mixes random bursts with simplified reads and tracks its own pointer. An error in the bit counter or the state shows up within one byte, as a missing or misplaced acknowledge or as SDA moving while SCL is high. A stale or missing snapshot shows only when the time bus changes during a read, so a directed case does exactly that.

// File: rtl/rtci2c_pkg.sv
package rtci2c_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_MACK
  } eng_st_t;

  typedef enum logic [1:0] {
    PH_HDR, PH_WADDR, PH_WDATA
  } rx_phase_t;

  // header compare: upper seven bits against the device address
  function automatic logic hdr_hit(input logic [7:0] b, input logic [6:0] dev);
    return b[7:1] == dev;
  endfunction

  // pointer step with natural wrap at the pointer width
  function automatic logic [5:0] ptr_step(input logic [5:0] p);
    return p + 6'd1;
  endfunction
endpackage

// File: rtl/rtci2c_linecond.sv
module rtci2c_linecond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt,
  output logic scl_hi_q
);
  logic sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_hi_q <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_hi_q <= scl_i;
      sda_q    <= sda_i;
    end
  end

  assign scl_rise  = !scl_hi_q && scl_i;
  assign scl_fall  = scl_hi_q && !scl_i;
  assign start_evt = scl_hi_q && scl_i && sda_q && !sda_i;
  assign stop_evt  = scl_hi_q && scl_i && !sda_q && sda_i;

  // R2: a line event is never taken as two kinds at once
  a_r2_evt_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({scl_rise, scl_fall, start_evt, stop_evt}));
endmodule

// File: rtl/rtci2c_snapshot.sv
module rtci2c_snapshot #(
  parameter int SNAP_N = 7,
  parameter int DATA_W = 8,
  parameter int PTR_W  = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     capture,
  input  logic [SNAP_N*DATA_W-1:0] time_i,
  input  logic [PTR_W-1:0]         sel,
  output logic [DATA_W-1:0]        sel_byte
);
  logic [DATA_W-1:0] snap [SNAP_N];

  for (genvar g = 0; g < SNAP_N; g++) begin : g_byte
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       snap[g] <= '0;
      else if (capture) snap[g] <= time_i[g*DATA_W +: DATA_W];
    end
  end

  always_comb begin
    sel_byte = '0;
    for (int i = 0; i < SNAP_N; i++)
      if (sel == PTR_W'(i)) sel_byte = snap[i];
  end

  // R10: the held copy of a byte changes only on a capture
  a_r10_snap_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> $stable(snap[0]));
endmodule

// File: rtl/rtci2c_engine.sv
module rtci2c_engine
  import rtci2c_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h68,
  parameter int PTR_W  = 6,
  parameter int DATA_W = 8,
  parameter int SNAP_N = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_fail,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic              scl_hi_q,
  input  logic [DATA_W-1:0] snap_byte,
  input  logic [DATA_W-1:0] rf_rdata,
  output logic [PTR_W-1:0]  rf_addr,
  output logic              rf_we,
  output logic [DATA_W-1:0] rf_wdata,
  output logic              snap_capture,
  output logic              sda_oe
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DATA_W - 1);

  eng_st_t           st;
  rx_phase_t         ph;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] sh;
  logic [DATA_W-1:0] tx;
  logic [PTR_W-1:0]  ptr;
  logic              rd;
  logic              mack;

  // named internal events
  logic bus_ok, byte_done, hdr_ok, fetch_sel_snap;
  logic [DATA_W-1:0] fetch;

  assign bus_ok         = !pwr_fail && !start_evt && !stop_evt;
  assign byte_done      = bus_ok && st == ST_RX && scl_fall && cnt == CNT_FULL;
  assign hdr_ok         = hdr_hit(sh, DEV_ADDR);
  assign fetch_sel_snap = ptr < PTR_W'(SNAP_N);
  assign fetch          = fetch_sel_snap ? snap_byte : rf_rdata;

  assign rf_addr      = ptr;
  assign rf_wdata     = sh;
  assign rf_we        = byte_done && ph == PH_WDATA;
  assign snap_capture = byte_done && ph == PH_HDR && hdr_ok && sh[0];
  assign sda_oe       = (st == ST_ACK) || (st == ST_TX && !tx[DATA_W-1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; ph <= PH_HDR; cnt <= '0; sh <= '0; tx <= '0;
      ptr <= '0; rd <= 1'b0; mack <= 1'b0;
    end else if (pwr_fail) begin
      st <= ST_IDLE; ptr <= '0; cnt <= '0; rd <= 1'b0;
    end else if (start_evt) begin
      st <= ST_RX; ph <= PH_HDR; cnt <= '0; rd <= 1'b0;
    end else if (stop_evt) begin
      st <= ST_IDLE;
    end else begin
      unique case (st)
        ST_RX: begin
          if (scl_rise && cnt < CNT_FULL) begin
            sh  <= {sh[DATA_W-2:0], sda_i};
            cnt <= cnt + 1'b1;
          end else if (byte_done) begin
            unique case (ph)
              PH_HDR: begin
                if (hdr_ok) begin
                  rd <= sh[0];
                  st <= ST_ACK;
                end else begin
                  st <= ST_IDLE;
                end
              end
              PH_WADDR: begin
                ptr <= sh[PTR_W-1:0];
                st  <= ST_ACK;
              end
              default: begin
                ptr <= ptr_step(ptr);
                st  <= ST_ACK;
              end
            endcase
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            cnt <= '0;
            if (rd) begin
              tx  <= fetch;
              ptr <= ptr_step(ptr);
              st  <= ST_TX;
            end else begin
              st <= ST_RX;
              ph <= (ph == PH_HDR) ? PH_WADDR : PH_WDATA;
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            tx  <= {tx[DATA_W-2:0], 1'b1};
            cnt <= cnt + 1'b1;
            if (cnt == CNT_LAST) st <= ST_MACK;
          end
        end
        ST_MACK: begin
          if (scl_rise) mack <= !sda_i;
          else if (scl_fall) begin
            if (mack) begin
              tx  <= fetch;
              ptr <= ptr_step(ptr);
              cnt <= '0;
              st  <= ST_TX;
            end else begin
              st <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  // R9: power fail leaves the pointer at zero and the line released
  a_r9_pf_clears: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_fail |=> (ptr == '0 && !sda_oe));

  // R3: every register write advances the pointer by one
  a_r3_write_steps_ptr: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |=> ptr == PTR_W'($past(ptr) + 1'b1));

  // R7: the slave never moves SDA while SCL stays high
  a_r7_sda_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_i && scl_hi_q && !pwr_fail && !$past(pwr_fail) && !start_evt)
      |-> $stable(sda_oe));

  // R8: an unacknowledged byte ends transmission with SDA released
  a_r8_nack_release: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_MACK && scl_fall && !mack && bus_ok) |=> !sda_oe);

  // R2: a STOP leaves SDA released
  a_r2_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_evt && !pwr_fail) |=> !sda_oe);
endmodule

// File: rtl/rtc_i2c_regif.sv
module rtc_i2c_regif #(
  parameter logic [6:0] DEV_ADDR = 7'h68,
  parameter int PTR_W  = 6,
  parameter int DATA_W = 8,
  parameter int SNAP_N = 7
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     scl_i,
  input  logic                     sda_i,
  output logic                     sda_oe,
  input  logic                     pwr_fail,
  input  logic [SNAP_N*DATA_W-1:0] time_i,
  output logic [PTR_W-1:0]         rf_addr,
  output logic                     rf_we,
  output logic [DATA_W-1:0]        rf_wdata,
  input  logic [DATA_W-1:0]        rf_rdata
);
  logic scl_rise, scl_fall, start_evt, stop_evt, scl_hi_q;
  logic snap_capture;
  logic [DATA_W-1:0] snap_byte;

  rtci2c_linecond u_cond (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt), .scl_hi_q(scl_hi_q)
  );

  rtci2c_snapshot #(.SNAP_N(SNAP_N), .DATA_W(DATA_W), .PTR_W(PTR_W)) u_snap (
    .clk(clk), .rst_n(rst_n), .capture(snap_capture), .time_i(time_i),
    .sel(rf_addr), .sel_byte(snap_byte)
  );

  rtci2c_engine #(
    .DEV_ADDR(DEV_ADDR), .PTR_W(PTR_W), .DATA_W(DATA_W), .SNAP_N(SNAP_N)
  ) u_eng (
    .clk(clk), .rst_n(rst_n), .pwr_fail(pwr_fail), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_evt(start_evt),
    .stop_evt(stop_evt), .scl_hi_q(scl_hi_q), .snap_byte(snap_byte),
    .rf_rdata(rf_rdata), .rf_addr(rf_addr), .rf_we(rf_we),
    .rf_wdata(rf_wdata), .snap_capture(snap_capture), .sda_oe(sda_oe)
  );
endmodule

// File: tb/rtc_i2c_regif_bench.sv
module rtc_i2c_regif_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, pwr_fail = 1'b0;
  logic sda_oe, sda_line, rf_we;
  logic [5:0] rf_addr;
  logic [7:0] rf_wdata, rf_rdata;
  logic [55:0] time_i, time_alt;
  logic use_alt = 1'b0;
  logic [7:0] mem [64];
  logic [7:0] exp_mem [64];
  logic [5:0] exp_ptr;
  int total = 0, bad = 0, we_cnt = 0, r7_viol = 0;
  logic scl_prev = 1'b1, oe_prev = 1'b0;

  always #4 clk = ~clk;

  assign sda_line = sda_m & ~sda_oe;
  assign rf_rdata = mem[rf_addr];
  always_comb for (int i = 0; i < 7; i++) time_alt[i*8 +: 8] = ~mem[i];
  always_comb begin
    for (int i = 0; i < 7; i++) time_i[i*8 +: 8] = mem[i];
    if (use_alt) time_i = time_alt;
  end
  always @(posedge clk) if (rf_we) begin mem[rf_addr] <= rf_wdata; we_cnt <= we_cnt + 1; end

  // R7 monitor: slave drive must not change while SCL is held high
  always @(negedge clk) begin
    if (rst_n && scl_m && scl_prev && !pwr_fail && sda_oe !== oe_prev) r7_viol++;
    scl_prev = scl_m; oe_prev = sda_oe;
  end

  rtc_i2c_regif u_rtc_i2c_regif (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .pwr_fail(pwr_fail), .time_i(time_i), .rf_addr(rf_addr), .rf_we(rf_we),
    .rf_wdata(rf_wdata), .rf_rdata(rf_rdata)
  );

  function automatic logic [7:0] hdr(input logic rw);
    return {7'b1101000, rw};
  endfunction

  task automatic check(input logic ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, expv);
    end
  endtask

  task automatic half(); repeat (4) @(negedge clk); endtask
  task automatic i_start();
    sda_m = 1'b1; half(); scl_m = 1'b1; half(); sda_m = 1'b0; half(); scl_m = 1'b0; half();
  endtask
  task automatic i_stop();
    sda_m = 1'b0; half(); scl_m = 1'b1; half(); sda_m = 1'b1; half();
  endtask
  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; half(); scl_m = 1'b1; half(); scl_m = 1'b0;
    end
    sda_m = 1'b1; half(); scl_m = 1'b1; half();
    ack = !sda_line;
    scl_m = 1'b0; half();
  endtask
  task automatic recv_byte(input logic mack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 0; i < 8; i++) begin
      half(); scl_m = 1'b1; half(); b = {b[6:0], sda_line}; scl_m = 1'b0;
    end
    half(); sda_m = !mack; half(); scl_m = 1'b1; half(); scl_m = 1'b0; half(); sda_m = 1'b1;
  endtask

  task automatic do_write(input logic [5:0] a, input int n, input string req);
    logic ack;
    i_start();
    send_byte(hdr(1'b0), ack); check(ack, "R1 write header ack", ack, 1);
    send_byte({2'b00, a}, ack); check(ack, "R3 address ack", ack, 1);
    exp_ptr = a;
    for (int i = 0; i < n; i++) begin
      logic [7:0] d;
      d = 8'($urandom);
      send_byte(d, ack); check(ack, req, ack, 1);
      exp_mem[exp_ptr] = d; exp_ptr = exp_ptr + 6'd1;
    end
    i_stop();
  endtask

  task automatic read_body(input int n, input string req);
    logic [7:0] b;
    for (int i = 0; i < n; i++) begin
      recv_byte(i != n - 1, b);
      check(b == exp_mem[exp_ptr], req, b, exp_mem[exp_ptr]);
      exp_ptr = exp_ptr + 6'd1;
    end
    i_stop();
  endtask

  task automatic std_read(input logic [5:0] a, input int n, input string req);
    logic ack;
    i_start();
    send_byte(hdr(1'b0), ack); send_byte({2'b00, a}, ack);
    i_start();
    send_byte(hdr(1'b1), ack); check(ack, "R1 read header ack", ack, 1);
    exp_ptr = a;
    read_body(n, req);
  endtask

  task automatic simple_read(input int n, input string req);
    logic ack;
    i_start();
    send_byte(hdr(1'b1), ack); check(ack, "R1 read header ack", ack, 1);
    read_body(n, req);
  endtask

  initial begin
    logic ack;
    logic [7:0] b;
    int wc;
    void'($urandom(32'd20250601));
    for (int i = 0; i < 64; i++) begin mem[i] = 8'(i * 7 + 3); exp_mem[i] = 8'(i * 7 + 3); end
    exp_ptr = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    half();
    check(sda_oe == 1'b0, "R2 reset releases SDA", sda_oe, 0);
    check(rf_addr == 6'd0, "R6 reset pointer", rf_addr, 0);

    // R1: foreign header is refused and the bus ignored
    wc = we_cnt;
    i_start();
    send_byte(8'hA0, ack); check(!ack, "R1 foreign header nack", ack, 0);
    send_byte(8'h05, ack); check(!ack, "R1 ignored byte nack", ack, 0);
    i_stop();
    check(we_cnt == wc, "R1 no write after mismatch", we_cnt - wc, 0);

    // R3 / R5 / R6
    do_write(6'h10, 3, "R3 data ack");
    std_read(6'h10, 3, "R5 standard read data");
    simple_read(2, "R6 simplified read continues");

    // R4 wrap on write and read
    do_write(6'h3E, 3, "R4 write across wrap");
    check(rf_addr == 6'h01, "R4 pointer after wrap", rf_addr, 1);
    std_read(6'h3F, 2, "R4 read across wrap");

    // R8: after master NACK the slave stays off the line
    std_read(6'h20, 1, "R8 single byte");
    i_start(); send_byte(hdr(1'b1), ack);
    recv_byte(1'b0, b);
    exp_ptr = exp_ptr + 6'd1;
    recv_byte(1'b0, b);
    check(b == 8'hFF, "R8 released after nack", b, 8'hFF);
    i_stop();

    // R10: snapshot survives a time change mid-burst
    std_read(6'h00, 1, "R10 first byte");
    i_start(); send_byte(hdr(1'b0), ack); send_byte(8'h00, ack);
    i_start(); send_byte(hdr(1'b1), ack);
    recv_byte(1'b1, b); check(b == exp_mem[0], "R10 byte 0", b, exp_mem[0]);
    use_alt = 1'b1;
    for (int i = 1; i < 7; i++) begin
      recv_byte(i != 6, b); check(b == exp_mem[i], "R10 snapshot held", b, exp_mem[i]);
    end
    i_stop();
    i_start(); send_byte(hdr(1'b0), ack); send_byte(8'h02, ack);
    i_start(); send_byte(hdr(1'b1), ack);
    recv_byte(1'b0, b); check(b == ~exp_mem[2], "R10 new capture", b, 8'(~exp_mem[2]));
    i_stop();
    use_alt = 1'b0;

    // R9: power fail mid-write
    wc = we_cnt;
    i_start(); send_byte(hdr(1'b0), ack); send_byte(8'h28, ack);
    for (int i = 7; i >= 4; i--) begin sda_m = 1'b0; half(); scl_m = 1'b1; half(); scl_m = 1'b0; end
    pwr_fail = 1'b1;
    half();
    check(sda_oe == 1'b0, "R9 SDA released", sda_oe, 0);
    check(rf_addr == 6'd0, "R9 pointer cleared", rf_addr, 0);
    for (int i = 3; i >= 0; i--) begin sda_m = 1'b0; half(); scl_m = 1'b1; half(); scl_m = 1'b0; end
    sda_m = 1'b1; half(); scl_m = 1'b1; half(); scl_m = 1'b0; half();
    i_stop();
    i_start(); send_byte(hdr(1'b0), ack); check(!ack, "R9 header ignored", ack, 0);
    i_stop();
    check(we_cnt == wc, "R9 no write", we_cnt - wc, 0);
    pwr_fail = 1'b0; half();
    exp_ptr = '0;
    simple_read(1, "R9 read from zero after abort");

    // random mix
    for (int it = 0; it < 40; it++) begin
      int op, n;
      op = int'($urandom_range(2, 0));
      n  = int'($urandom_range(4, 1));
      if (op == 0) do_write(6'($urandom), n, "R3 random write ack");
      else if (op == 1) std_read(6'($urandom), n, "R5 random standard read");
      else simple_read(n, "R6 random simplified read");
    end

    check(r7_viol == 0, "R7 SDA steady while SCL high", r7_viol, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule